// File: doc/BRIEF.md
# CAM Coprocessor Host Control Front End

This block sits between a host's synchronous control bus and a small content-addressable memory array. Each accepted clock edge becomes one operation. Register operations touch a local register file: a comparand, seven mask registers, configuration, status, an address pointer, a device-select register and an instruction register. Array operations become single-cycle request strobes to the array, with address, data, mask and validity bit attached.

The block has two control modes. In hardware mode the address/control bus carries either an array address (address-valid low) or a control code (address-valid high). A data-segment input chooses which 16-bit half of a register a write updates. In software mode the host sends an instruction word on the data bus with address-valid high, then sends a data word with address-valid low, and that data word executes the stored instruction. Array accesses in software mode go only through the auto-incrementing address register.

The device responds when either active-low chip select is low, or when its device-select register is enabled and matches its own page number. Several devices can therefore share one bus.

Top module: `camhost_ctl`

## Requirements
- R1: After synchronous reset the following hold, and no strobe or `rd_valid` is high.
  - Configuration reads 0: hardware mode, page 0, write-mask index 0.
  - All mask registers, the comparand, the address register and status read 0.
  - Device-select reads 0x10: enable bit high, so matching is disabled.
- R2: An operation is accepted only on an edge where `ce_n` is low and the device is selected. Other edges produce no strobe, no `rd_valid` and no register change.
- R3: The device is selected when `cs1_n` is low or `cs2_n` is low. It is also selected when device-select bit 4 (active-low enable) is 0 and device-select bits 3:0 equal configuration bits 3:0 (page).
- R4: In hardware mode with `av_n` high, `ac[7:4]` is the opcode and `ac[3:0]` the register index.
  - Opcodes: 0 no-op, 1 register write, 2 register read, 3 compare, 4 indirect read, 5 indirect write, 6 validity set, 7 address load; other codes are no-ops.
  - Register indices: 0 comparand, 1..7 masks, 8 configuration, 9 status, 10 address, 11 device-select, 12 instruction.
  - Any other index reads 0.
- R5: In hardware mode a register write updates bits 15:0 when `dseg`=0 and bits 31:16 when `dseg`=1. In software mode it updates the whole word. Writes to status are ignored.
- R6: A register read raises `rd_valid` for one cycle with the register value on `rd_data`, in the cycle after the accepting edge.
- R7: In hardware mode with `av_n` low:
  - With `we_n` low, `arr_wr` pulses at address `ac`, with `arr_wdata`=`dq_in` and `arr_vbit`=`vbit_in`. `arr_mask` is the mask register chosen by configuration bits 6:4, and index 0 gives all zeros.
  - With `we_n` high, `arr_rd` pulses at address `ac`.
- R8: Compare pulses `arr_cmp` with `arr_wdata` equal to the comparand and `arr_mask` equal to the mask register whose number is in bits 2:0 of the register index (0 gives all zeros).
- R9: Indirect read, indirect write and validity set use the address register as the array address, then increment it, wrapping modulo 2^8.
  - Indirect write uses the write mask of R7.
  - Validity set pulses `arr_vb` with `arr_vbit`=`vbit_in`.
  - Address load sets the address register to `dq_in[7:0]`.
- R10: With configuration bit 7 set (software mode):
  - `av_n` high loads `dq_in[7:0]` into the instruction register and produces no strobe.
  - `av_n` low executes the stored instruction, using the R4 encoding, with `dq_in` as data. `ac` and `we_n` are ignored, so no direct array access happens.
- R11: Configuration holds page in bits 3:0, write-mask index in bits 6:4 and mode in bit 7. Bits above 7 read 0.
- R12: Status bits 7:0 hold the address of the most recent array access, and bit 31 becomes 1 after the first array access.
- R13: At most one of `arr_rd`, `arr_wr`, `arr_cmp`, `arr_vb`, `rd_valid` is high in any cycle. `arr_addr` holds its value between array accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2_n | input | 1 | Chip select 2, active low |
| we_n | input | 1 | Write enable for direct array access, active low |
| av_n | input | 1 | Address-valid: low means address/data, high means control/instruction |
| vbit_in | input | 1 | Validity bit for array writes and validity set |
| dseg | input | 1 | Register half select in hardware mode |
| ac | input | AW (8) | Address/control bus |
| dq_in | input | DW (32) | Host data bus |
| rd_data | output | DW (32) | Register read data |
| rd_valid | output | 1 | Register read data valid |
| arr_rd | output | 1 | Array read request |
| arr_wr | output | 1 | Array write request |
| arr_cmp | output | 1 | Array compare request |
| arr_vb | output | 1 | Array validity-bit update request |
| arr_addr | output | AW (8) | Array address, held between accesses |
| arr_wdata | output | DW (32) | Write data or comparand |
| arr_mask | output | DW (32) | Bit mask for write or compare |
| arr_vbit | output | 1 | Validity bit value for the request |

## Verification
A wrong configuration or device-select value shows up as a wrong `rd_valid` or strobe on the next accepted edge. It also shows as a wrong `arr_mask` on the first direct write or compare after the fault. A stuck or mis-stepped address register shows on `arr_addr` at the next indirect access, one cycle after the accepting edge. An instruction register that is loaded wrongly shows on the first software-mode data word. The bench sweeps every chip-select and enable combination, every device-select page, every mask index for both write and compare, and the address wrap at the top of the array.

// File: rtl/camhost_pkg.sv
package camhost_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'h0,
    OP_REG_WR = 4'h1,
    OP_REG_RD = 4'h2,
    OP_CMP    = 4'h3,
    OP_IND_RD = 4'h4,
    OP_IND_WR = 4'h5,
    OP_VB_SET = 4'h6,
    OP_ADR_LD = 4'h7
  } op_e;

  localparam logic [3:0] RI_CMP   = 4'd0;
  localparam logic [3:0] RI_CFG   = 4'd8;
  localparam logic [3:0] RI_STAT  = 4'd9;
  localparam logic [3:0] RI_ADR   = 4'd10;
  localparam logic [3:0] RI_DSEL  = 4'd11;
  localparam logic [3:0] RI_INSTR = 4'd12;

  typedef struct packed {
    logic reg_wr;
    logic reg_rd;
    logic cmp;
    logic ind_rd;
    logic ind_wr;
    logic vb_set;
    logic adr_ld;
    logic dir_rd;
    logic dir_wr;
    logic ir_ld;
  } act_t;

endpackage

// File: rtl/camhost_decode.sv
module camhost_decode
  import camhost_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic       sw_mode,
  input  logic       av_n,
  input  logic       we_n,
  input  logic [7:0] ac_code,
  input  logic [7:0] instr,
  output act_t       act,
  output logic [3:0] ridx
);

  logic [7:0] code;

  always_comb begin
    act  = '0;
    code = sw_mode ? instr : ac_code;
    ridx = code[3:0];
    if (accept) begin
      if (!sw_mode && !av_n) begin
        act.dir_wr = !we_n;
        act.dir_rd = we_n;
      end else if (sw_mode && av_n) begin
        act.ir_ld = 1'b1;
      end else begin
        case (op_e'(code[7:4]))
          OP_REG_WR: act.reg_wr = 1'b1;
          OP_REG_RD: act.reg_rd = 1'b1;
          OP_CMP:    act.cmp    = 1'b1;
          OP_IND_RD: act.ind_rd = 1'b1;
          OP_IND_WR: act.ind_wr = 1'b1;
          OP_VB_SET: act.vb_set = 1'b1;
          OP_ADR_LD: act.adr_ld = 1'b1;
          default:   act        = '0;
        endcase
      end
    end
  end

  AST_SW_NO_DIRECT: assert property (@(posedge clk) disable iff (rst)
    sw_mode |-> !(act.dir_rd || act.dir_wr)); // R10

endmodule

// File: rtl/camhost_regs.sv
module camhost_regs
  import camhost_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int PGW   = 4,
  parameter int NMASK = 7,
  parameter int ICW   = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  act_t           act,
  input  logic [3:0]     ridx,
  input  logic [DW-1:0]  wdata,
  input  logic           be_lo,
  input  logic           be_hi,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  output logic [DW-1:0]  rd_val,
  output logic [DW-1:0]  cmp_q,
  output logic [DW-1:0]  mask_cmp,
  output logic [DW-1:0]  mask_wr,
  output logic           sw_mode,
  output logic           dsel_hit,
  output logic [AW-1:0]  addr_q,
  output logic [ICW-1:0] instr_q
);

  localparam int MIW  = $clog2(NMASK + 1);
  localparam int NENT = 1 << MIW;
  localparam int CFGW = PGW + MIW + 1;
  localparam int DSW  = PGW + 1;
  localparam int HALF = DW / 2;

  logic [DW-1:0]   mask_q [NENT];
  logic [CFGW-1:0] cfg_q;
  logic [DSW-1:0]  dsel_q;
  logic [AW-1:0]   stat_addr;
  logic            stat_seen;

  logic [DW-1:0] wmask, m_cmp, m_mask, m_cfg, m_adr, m_dsel, m_ir;
  logic [MIW-1:0] widx, ridx_m;
  logic           is_mask;

  assign wmask  = {{(DW - HALF){be_hi}}, {HALF{be_lo}}};
  assign ridx_m = ridx[MIW-1:0];
  assign is_mask = (ridx != RI_CMP) && (ridx <= NMASK);
  assign widx   = cfg_q[PGW+MIW-1:PGW];

  always_comb begin
    m_cmp  = (cmp_q & ~wmask)              | (wdata & wmask);
    m_mask = (mask_q[ridx_m] & ~wmask)     | (wdata & wmask);
    m_cfg  = (DW'(cfg_q) & ~wmask)         | (wdata & wmask);
    m_adr  = (DW'(addr_q) & ~wmask)        | (wdata & wmask);
    m_dsel = (DW'(dsel_q) & ~wmask)        | (wdata & wmask);
    m_ir   = (DW'(instr_q) & ~wmask)       | (wdata & wmask);
  end

  // Mask file: entry 0 is never written and stands for "no mask".
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NENT; i++) mask_q[i] <= '0;
    end else if (act.reg_wr && is_mask) begin
      mask_q[ridx_m] <= m_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q     <= '0;
      cfg_q     <= '0;
      dsel_q    <= {1'b1, {PGW{1'b0}}};
      instr_q   <= '0;
      stat_addr <= '0;
      stat_seen <= 1'b0;
    end else begin
      if (act.reg_wr) begin
        case (ridx)
          RI_CMP:   cmp_q   <= m_cmp;
          RI_CFG:   cfg_q   <= m_cfg[CFGW-1:0];
          RI_DSEL:  dsel_q  <= m_dsel[DSW-1:0];
          RI_INSTR: instr_q <= m_ir[ICW-1:0];
          default: ;
        endcase
      end
      if (act.ir_ld) instr_q <= wdata[ICW-1:0];
      if (acc_valid) begin
        stat_addr <= acc_addr;
        stat_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (act.adr_ld)
      addr_q <= wdata[AW-1:0];
    else if (act.reg_wr && ridx == RI_ADR)
      addr_q <= m_adr[AW-1:0];
    else if (act.ind_rd || act.ind_wr || act.vb_set)
      addr_q <= addr_q + 1'b1;
  end

  always_comb begin
    rd_val = '0;
    if (ridx == RI_CMP) begin
      rd_val = cmp_q;
    end else if (is_mask) begin
      rd_val = mask_q[ridx_m];
    end else begin
      case (ridx)
        RI_CFG:   rd_val = DW'(cfg_q);
        RI_STAT: begin
          rd_val         = DW'(stat_addr);
          rd_val[DW-1]   = stat_seen;
        end
        RI_ADR:   rd_val = DW'(addr_q);
        RI_DSEL:  rd_val = DW'(dsel_q);
        RI_INSTR: rd_val = DW'(instr_q);
        default:  rd_val = '0;
      endcase
    end
  end

  assign mask_cmp = mask_q[ridx_m];
  assign mask_wr  = mask_q[widx];
  assign sw_mode  = cfg_q[CFGW-1];
  assign dsel_hit = !dsel_q[PGW] && (dsel_q[PGW-1:0] == cfg_q[PGW-1:0]);

  AST_CFG_RESET: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && addr_q == '0 && !stat_seen)); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (act.ind_rd || act.ind_wr || act.vb_set) |=> addr_q == AW'($past(addr_q) + 1'b1)); // R9
  AST_STATUS_MARK: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (stat_seen && stat_addr == $past(acc_addr))); // R12

endmodule

// File: rtl/camhost_ctl.sv
module camhost_ctl
  import camhost_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int PGW   = 4,
  parameter int NMASK = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          cs1_n,
  input  logic          cs2_n,
  input  logic          we_n,
  input  logic          av_n,
  input  logic          vbit_in,
  input  logic          dseg,
  input  logic [AW-1:0] ac,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          arr_rd,
  output logic          arr_wr,
  output logic          arr_cmp,
  output logic          arr_vb,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic [DW-1:0] arr_mask,
  output logic          arr_vbit
);

  localparam int ICW = 8;

  act_t           act;
  logic [3:0]     ridx;
  logic           sw_mode, dsel_hit, sel, accept;
  logic           be_lo, be_hi, acc_valid, wr_any;
  logic [AW-1:0]  addr_q, acc_addr;
  logic [ICW-1:0] instr_q;
  logic [DW-1:0]  rd_val, cmp_q, mask_cmp, mask_wr;

  assign sel    = !cs1_n || !cs2_n || dsel_hit;
  assign accept = !ce_n && sel;
  assign be_lo  = sw_mode || !dseg;
  assign be_hi  = sw_mode || dseg;

  camhost_decode u_dec (
    .clk(clk), .rst(rst), .accept(accept), .sw_mode(sw_mode),
    .av_n(av_n), .we_n(we_n), .ac_code(ac[7:0]), .instr(instr_q),
    .act(act), .ridx(ridx)
  );

  assign acc_valid = act.dir_rd || act.dir_wr || act.ind_rd || act.ind_wr || act.vb_set;
  assign acc_addr  = (act.dir_rd || act.dir_wr) ? ac : addr_q;
  assign wr_any    = act.dir_wr || act.ind_wr;

  camhost_regs #(.AW(AW), .DW(DW), .PGW(PGW), .NMASK(NMASK), .ICW(ICW)) u_regs (
    .clk(clk), .rst(rst), .act(act), .ridx(ridx), .wdata(dq_in),
    .be_lo(be_lo), .be_hi(be_hi), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .rd_val(rd_val), .cmp_q(cmp_q), .mask_cmp(mask_cmp), .mask_wr(mask_wr),
    .sw_mode(sw_mode), .dsel_hit(dsel_hit), .addr_q(addr_q), .instr_q(instr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      arr_rd    <= 1'b0;
      arr_wr    <= 1'b0;
      arr_cmp   <= 1'b0;
      arr_vb    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
      arr_mask  <= '0;
      arr_vbit  <= 1'b0;
    end else begin
      rd_valid <= act.reg_rd;
      arr_rd   <= act.dir_rd || act.ind_rd;
      arr_wr   <= wr_any;
      arr_cmp  <= act.cmp;
      arr_vb   <= act.vb_set;
      if (acc_valid) arr_addr <= acc_addr;
      if (act.reg_rd) rd_data <= rd_val;
      if (wr_any) begin
        arr_wdata <= dq_in;
        arr_mask  <= mask_wr;
        arr_vbit  <= vbit_in;
      end else if (act.cmp) begin
        arr_wdata <= cmp_q;
        arr_mask  <= mask_cmp;
      end else if (act.vb_set) begin
        arr_vbit  <= vbit_in;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arr_rd, arr_wr, arr_cmp, arr_vb, rd_valid})); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !(arr_rd || arr_wr || arr_cmp || arr_vb || rd_valid)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(act.dir_rd || act.dir_wr || act.ind_rd || act.ind_wr || act.vb_set) |=> $stable(arr_addr)); // R13

endmodule

// File: tb/sim_camhost_ctl.sv
module sim_camhost_ctl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, cs1_n = 1'b1, cs2_n = 1'b1, we_n = 1'b1, av_n = 1'b1;
  logic        vbit_in = 1'b0, dseg = 1'b0;
  logic [7:0]  ac = '0;
  logic [31:0] dq_in = '0;
  logic [31:0] rd_data, arr_wdata, arr_mask;
  logic [7:0]  arr_addr;
  logic        rd_valid, arr_rd, arr_wr, arr_cmp, arr_vb, arr_vbit;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mexp [8];

  always #(CLK_PERIOD / 2) clk = ~clk;

  camhost_ctl u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cs1_n(cs1_n), .cs2_n(cs2_n),
    .we_n(we_n), .av_n(av_n), .vbit_in(vbit_in), .dseg(dseg), .ac(ac),
    .dq_in(dq_in), .rd_data(rd_data), .rd_valid(rd_valid), .arr_rd(arr_rd),
    .arr_wr(arr_wr), .arr_cmp(arr_cmp), .arr_vb(arr_vb), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_mask(arr_mask), .arr_vbit(arr_vbit)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; cs1_n = 1; cs2_n = 1; we_n = 1; av_n = 1; vbit_in = 0; dseg = 0; ac = '0; dq_in = '0;
  endtask

  // Drives one cycle at a falling edge; returns at the falling edge after the capturing edge.
  task automatic pulse(input logic ce, input logic c1, input logic c2, input logic we,
                       input logic av, input logic vb, input logic ds,
                       input logic [7:0] a, input logic [31:0] d);
    ce_n = ce; cs1_n = c1; cs2_n = c2; we_n = we; av_n = av; vbit_in = vb; dseg = ds;
    ac = a; dq_in = d;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic hw(input logic [3:0] op, input logic [3:0] idx, input logic [31:0] d,
                    input logic ds, input logic vb);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, vb, ds, {op, idx}, d);
  endtask

  task automatic wr_full(input logic [3:0] idx, input logic [31:0] v);
    hw(4'h1, idx, v, 1'b0, 1'b0);
    hw(4'h1, idx, v, 1'b1, 1'b0);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] idx, input logic [31:0] exp);
    hw(4'h2, idx, 32'h0, 1'b0, 1'b0);
    check({req, " rd_valid"}, {31'b0, rd_valid}, 32'h1);
    check(req, rd_data, exp);
  endtask

  function automatic logic [3:0] strobes();
    return {arr_rd, arr_wr, arr_cmp, arr_vb};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    mexp[0] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 strobes after reset", {27'b0, strobes(), rd_valid}, 32'h0);
    rd_chk("R1 config", 4'd8, 32'h0);
    rd_chk("R1 comparand", 4'd0, 32'h0);
    for (int i = 1; i < 8; i++) rd_chk("R1 mask", i[3:0], 32'h0);
    rd_chk("R1 devsel", 4'd11, 32'h10);
    rd_chk("R1 addr", 4'd10, 32'h0);
    rd_chk("R12 status at reset", 4'd9, 32'h0);
    rd_chk("R4 unused index", 4'd14, 32'h0);

    // R5 half writes, status write ignored
    hw(4'h1, 4'd0, 32'h5555_1234, 1'b0, 1'b0);
    rd_chk("R5 low half", 4'd0, 32'h0000_1234);
    hw(4'h1, 4'd0, 32'hABCD_9999, 1'b1, 1'b0);
    rd_chk("R5 high half", 4'd0, 32'hABCD_1234);
    wr_full(4'd9, 32'hFFFF_FFFF);
    rd_chk("R5 status read-only", 4'd9, 32'h0);

    // R4/R6 mask sweep
    for (int i = 1; i < 8; i++) begin
      mexp[i] = (32'h1111_1111 * i) ^ 32'hA5A5_0000;
      wr_full(i[3:0], mexp[i]);
    end
    for (int i = 1; i < 8; i++) rd_chk("R6 mask readback", i[3:0], mexp[i]);

    // R11 config layout
    wr_full(4'd8, 32'hFFFF_FF75);
    rd_chk("R11 config width", 4'd8, 32'h0000_0075);
    wr_full(4'd8, 32'h0);

    // R2/R3 chip select and enable sweep
    for (int k = 0; k < 8; k++) begin
      pulse(k[2], k[1], k[0], 1'b1, 1'b1, 1'b0, 1'b0, 8'h20, 32'h0);
      check("R2 R3 select sweep", {31'b0, rd_valid}, {31'b0, !k[2] && (!k[1] || !k[0])});
    end
    pulse(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h10, 32'hDEAD_BEEF);
    rd_chk("R2 deselected write ignored", 4'd0, 32'hABCD_1234);
    pulse(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h10, 32'hDEAD_BEEF);
    rd_chk("R2 disabled write ignored", 4'd0, 32'hABCD_1234);

    // R3 device-select page match
    wr_full(4'd8, 32'h5);
    for (int p = 0; p < 16; p++) begin
      wr_full(4'd11, p);
      pulse(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h20, 32'h0);
      check("R3 page match", {31'b0, rd_valid}, {31'b0, p == 5});
    end
    wr_full(4'd11, 32'h15);
    pulse(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h20, 32'h0);
    check("R3 enable bit high", {31'b0, rd_valid}, 32'h0);
    wr_full(4'd11, 32'h10);

    // R7 direct access for each write-mask index
    for (int k = 0; k < 8; k++) begin
      wr_full(4'd8, k << 4);
      pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, k[0], 1'b0, 8'h30 + k[7:0], 32'hC0DE_0000 + k);
      check("R7 wr strobe", {28'b0, strobes()}, 32'h4);
      check("R13 no read valid on write", {31'b0, rd_valid}, 32'h0);
      check("R7 wr addr", {24'b0, arr_addr}, 32'h30 + k);
      check("R7 wr data", arr_wdata, 32'hC0DE_0000 + k);
      check("R7 wr vbit", {31'b0, arr_vbit}, {31'b0, k[0]});
      check("R7 wr mask", arr_mask, mexp[k]);
      pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80 + k[7:0], 32'h0);
      check("R7 rd strobe", {28'b0, strobes()}, 32'h8);
      check("R7 rd addr", {24'b0, arr_addr}, 32'h80 + k);
    end
    rd_chk("R12 status after access", 4'd9, 32'h8000_0087);
    rd_chk("R13 addr held", {28'b0, 4'd9}, 32'h8000_0087);
    check("R13 arr_addr held over reg ops", {24'b0, arr_addr}, 32'h87);

    // R8 compare with each mask
    wr_full(4'd8, 32'h0);
    wr_full(4'd0, 32'h1357_9BDF);
    for (int m = 0; m < 8; m++) begin
      hw(4'h3, m[3:0], 32'h0, 1'b0, 1'b0);
      check("R8 cmp strobe", {28'b0, strobes()}, 32'h2);
      check("R8 cmp data", arr_wdata, 32'h1357_9BDF);
      check("R8 cmp mask", arr_mask, mexp[m]);
    end

    // R9 indirect walk with wrap
    hw(4'h7, 4'd0, 32'h0000_00FE, 1'b0, 1'b0);
    hw(4'h5, 4'd0, 32'h0BAD_F00D, 1'b0, 1'b1);
    check("R9 ind wr strobe", {28'b0, strobes()}, 32'h4);
    check("R9 ind wr addr", {24'b0, arr_addr}, 32'hFE);
    check("R9 ind wr data", arr_wdata, 32'h0BAD_F00D);
    check("R9 ind wr vbit", {31'b0, arr_vbit}, 32'h1);
    hw(4'h5, 4'd0, 32'h1, 1'b0, 1'b0);
    check("R9 ind wr step", {24'b0, arr_addr}, 32'hFF);
    hw(4'h4, 4'd0, 32'h0, 1'b0, 1'b0);
    check("R9 ind rd wrap", {24'b0, arr_addr}, 32'h00);
    check("R9 ind rd strobe", {28'b0, strobes()}, 32'h8);
    hw(4'h6, 4'd0, 32'h0, 1'b0, 1'b1);
    check("R9 vb strobe", {28'b0, strobes()}, 32'h1);
    check("R9 vb addr", {24'b0, arr_addr}, 32'h01);
    check("R9 vb value", {31'b0, arr_vbit}, 32'h1);
    rd_chk("R9 addr after walk", 4'd10, 32'h2);

    // R10 software mode
    wr_full(4'd8, 32'h80);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 32'h50);
    check("R10 instr load no strobe", {27'b0, strobes(), rd_valid}, 32'h0);
    pulse(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h77, 32'h7777_AAAA);
    check("R10 exec ind wr", {28'b0, strobes()}, 32'h4);
    check("R10 addr from pointer", {24'b0, arr_addr}, 32'h02);
    check("R10 data word", arr_wdata, 32'h7777_AAAA);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h66, 32'h1);
    check("R10 pointer walk", {24'b0, arr_addr}, 32'h03);
    check("R10 we_n ignored", {28'b0, strobes()}, 32'h4);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 32'h2A);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 32'h0);
    check("R10 sw reg read valid", {31'b0, rd_valid}, 32'h1);
    check("R10 sw reg read", rd_data, 32'h4);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 32'h10);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 32'hFEDC_BA98);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 32'h18);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0);
    rd_chk("R5 sw full-word write", 4'd0, 32'hFEDC_BA98);
    pulse(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h44, 32'h0);
    check("R10 back to hardware direct", {24'b0, arr_addr}, 32'h44);
    check("R10 back to hardware strobe", {28'b0, strobes()}, 32'h8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule